// File: doc/BRIEF.md
# Interrupt Input Debounce Unit

This block filters a group of raw external interrupt lines before they reach the interrupt detect logic. Each channel can be switched into a filtered mode. In that mode its output follows the input only after the input has held a new level for a chosen interval. A 3-bit time code picks one of seven fixed, non-linear intervals, from 0.5 ms up to 256 ms. A free-running divider turns the system clock into a one-microsecond tick, and the counters count these ticks.

Each channel is configured through an 8-bit field. Four fields share one 32-bit word, and the words sit at three views: a read-only view, a write-one-to-set view and a write-one-to-clear view. A self-clearing bit in the field restarts the channel's counter. Filtering takes effect only on channels below a configured count, and only when the channel is marked level-sensitive. Every other channel passes its input straight through.

Top module: `dbx_debounce`

## Requirements
- R1: Channel n's field sits in the word at offset 4*(n/4) from a base and in byte lane 8*(n%4). Bit 0 of the field is the enable and bits 6:4 are the time code. Reads return the word one clock after `rd_addr` is presented, at base 0x500. Bits 7, 3 and 2 of every lane read as 0, and any unmatched address reads as 0.
- R2: A write to the set view at 0x600 ORs the enable and code bits of each lane into its field. A write to the clear view at 0x700 clears every field bit written as 1. A clear write of 0xFF to a lane wipes that whole field.
- R3: Writing 1 to bit 1 of a lane through the set view restarts that channel's count no later than two clocks after the write. Bit 1 always reads as 0, and the clear view ignores it.
- R4: Time codes 0 to 6 select 500, 1000, 16000, 32000, 64000, 128000 and 256000 microseconds. Code 7 selects 256000. One microsecond equals `CLK_PER_US` clocks.
- R5: A filtered channel changes its output only after the registered input has differed from it for the whole selected interval. The timing has a granularity of one tick. Any return to the output's level before then restarts the count from zero.
- R6: When a channel's enable is 0, or its `lvl_mode` bit is 0, its output equals its input delayed by two clocks.
- R7: Channels at or above `DBNC_CH` have no storage. Their field reads as 0, writes to it are ignored, and the channel always bypasses as in R6.
- R8: While `rst` is high, every output, every field and `rd_data` go to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address (set or clear view) |
| wr_data | input | 32 | Write data, one byte lane per channel |
| rd_addr | input | ADDR_W | Read byte address (read view) |
| rd_data | output | 32 | Registered read data |
| lvl_mode | input | NUM_CH | Per-channel level-sensitive flag from interrupt config |
| raw_in | input | NUM_CH | Raw interrupt inputs |
| filt_out | output | NUM_CH | Filtered interrupt outputs |

## Verification
The filter is driven with three kinds of input step. A clean step held past the interval shows that the output waits for the full interval and not a tick less. A short glitch followed by a second step shows that the count restarts and does not accumulate. A step with a mid-interval restart write shows that the restart takes effect. A 1000 µs code, a 16000 µs code and code 7 tell apart the table entries and confirm that code 7 is longer than code 2. The bypass paths are exercised separately: edge mode, a channel with enable off, and a channel above the debounce count. In each of them the output follows the input two clocks later whatever the field holds.

// File: rtl/dbx_pkg.sv
package dbx_pkg;
  localparam int TIME_W = 18;

  function automatic logic [TIME_W-1:0] dbx_interval_us(input logic [2:0] code);
    case (code)
      3'd0:    return TIME_W'(500);
      3'd1:    return TIME_W'(1000);
      3'd2:    return TIME_W'(16000);
      3'd3:    return TIME_W'(32000);
      3'd4:    return TIME_W'(64000);
      3'd5:    return TIME_W'(128000);
      default: return TIME_W'(256000);
    endcase
  endfunction
endpackage

// File: rtl/dbx_tick.sv
module dbx_tick #(
  parameter int CLK_PER_US = 100
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int DIV_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(CLK_PER_US - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      tick_o <= 1'b0;
    end else if (div_q == LAST) begin
      div_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      div_q  <= div_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dbx_regs.sv
module dbx_regs #(
  parameter int NUM_CH = 32,
  parameter int DBNC_CH = 16,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] RD_BASE  = 12'h500,
  parameter logic [ADDR_W-1:0] SET_BASE = 12'h600,
  parameter logic [ADDR_W-1:0] CLR_BASE = 12'h700
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [31:0]            wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [31:0]            rd_data,
  output logic [NUM_CH-1:0]      en_o,
  output logic [NUM_CH-1:0][2:0] code_o,
  output logic [NUM_CH-1:0]      cnt_clr_o
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    if (n < DBNC_CH) begin : g_live
      localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_BASE + 4 * (n / 4));
      localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_BASE + 4 * (n / 4));
      localparam int LANE = 8 * (n % 4);

      logic [7:0] lane_b;
      logic       en_q;
      logic [2:0] code_q;
      logic       clr_q;

      assign lane_b = wr_data[LANE +: 8];

      always_ff @(posedge clk) begin
        if (rst) begin
          en_q   <= 1'b0;
          code_q <= 3'd0;
          clr_q  <= 1'b0;
        end else begin
          clr_q <= 1'b0;
          if (wr_en && wr_addr == SET_A) begin
            en_q   <= en_q | lane_b[0];
            code_q <= code_q | lane_b[6:4];
            clr_q  <= lane_b[1];
          end else if (wr_en && wr_addr == CLR_A) begin
            en_q   <= en_q & ~lane_b[0];
            code_q <= code_q & ~lane_b[6:4];
          end
        end
      end

      assign en_o[n]      = en_q;
      assign code_o[n]    = code_q;
      assign cnt_clr_o[n] = clr_q;
    end else begin : g_none
      assign en_o[n]      = 1'b0;
      assign code_o[n]    = 3'd0;
      assign cnt_clr_o[n] = 1'b0;
    end
  end

  logic [31:0] rd_next;

  always_comb begin
    rd_next = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (rd_addr == ADDR_W'(RD_BASE + 4 * (n / 4)))
        rd_next[8 * (n % 4) +: 8] = {1'b0, code_o[n], 3'b000, en_o[n]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/dbx_chan.sv
module dbx_chan
  import dbx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       active,
  input  logic [2:0] code,
  input  logic       cnt_clr,
  input  logic       raw,
  output logic       filt
);
  logic [TIME_W-1:0] cnt_q;
  logic [TIME_W-1:0] lim;

  assign lim = dbx_interval_us(code);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      filt  <= 1'b0;
    end else if (!active) begin
      cnt_q <= '0;
      filt  <= raw;
    end else if (cnt_clr || raw == filt) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q >= lim - 1'b1) begin
        cnt_q <= '0;
        filt  <= raw;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbx_debounce.sv
module dbx_debounce #(
  parameter int NUM_CH = 32,
  parameter int DBNC_CH = 16,
  parameter int CLK_PER_US = 100,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] RD_BASE  = 12'h500,
  parameter logic [ADDR_W-1:0] SET_BASE = 12'h600,
  parameter logic [ADDR_W-1:0] CLR_BASE = 12'h700
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic [NUM_CH-1:0] lvl_mode,
  input  logic [NUM_CH-1:0] raw_in,
  output logic [NUM_CH-1:0] filt_out
);
  logic                   tick;
  logic [NUM_CH-1:0]      en;
  logic [NUM_CH-1:0][2:0] code;
  logic [NUM_CH-1:0]      cnt_clr;
  logic [NUM_CH-1:0]      raw_q;
  logic [NUM_CH-1:0]      dbn_active;

  dbx_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  dbx_regs #(
    .NUM_CH(NUM_CH), .DBNC_CH(DBNC_CH), .ADDR_W(ADDR_W),
    .RD_BASE(RD_BASE), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .en_o(en), .code_o(code),
    .cnt_clr_o(cnt_clr)
  );

  always_ff @(posedge clk) begin
    if (rst) raw_q <= '0;
    else     raw_q <= raw_in;
  end

  assign dbn_active = en & lvl_mode;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_filt
    dbx_chan u_chan (
      .clk(clk), .rst(rst), .tick(tick), .active(dbn_active[n]),
      .code(code[n]), .cnt_clr(cnt_clr[n]), .raw(raw_q[n]),
      .filt(filt_out[n])
    );
  end
endmodule

// File: rtl/dbx_debounce_chk.sv
module dbx_debounce_chk #(
  parameter int NUM_CH = 32,
  parameter int DBNC_CH = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] raw_in,
  input logic [NUM_CH-1:0] filt_out,
  input logic [31:0]       rd_data,
  input logic              tick,
  input logic [NUM_CH-1:0] dbn_active
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst)           age <= 2'd0;
    else if (age != 3) age <= age + 2'd1;
  end

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (age >= 1) |-> ((rd_data & 32'h8C8C_8C8C) == 32'h0));

  p_restart_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (age >= 1) |-> ((rd_data & 32'h0202_0202) == 32'h0));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    p_follow_input_r5: assert property (@(posedge clk) disable iff (rst)
      (age >= 2 && !$stable(filt_out[n])) |-> filt_out[n] == $past(raw_in[n], 2));

    p_wait_tick_r5: assert property (@(posedge clk) disable iff (rst)
      (age >= 2 && !$stable(filt_out[n]) && $past(dbn_active[n])) |-> $past(tick));

    p_bypass_r6: assert property (@(posedge clk) disable iff (rst)
      (age >= 2 && $past(!dbn_active[n])) |-> filt_out[n] == $past(raw_in[n], 2));

    if (n >= DBNC_CH) begin : g_beyond
      p_no_live_r7: assert property (@(posedge clk) disable iff (rst)
        !dbn_active[n]);
    end
  end
endmodule

bind dbx_debounce dbx_debounce_chk #(.NUM_CH(NUM_CH), .DBNC_CH(DBNC_CH)) u_chk (
  .clk(clk), .rst(rst), .raw_in(raw_in), .filt_out(filt_out),
  .rd_data(rd_data), .tick(tick), .dbn_active(dbn_active)
);

// File: tb/tb_dbx_debounce.sv
module tb_dbx_debounce;
  localparam int NUM_CH = 8;
  localparam int DBNC_CH = 6;
  localparam int P = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [11:0] rd_addr = 12'h500;
  logic [31:0] rd_data;
  logic [NUM_CH-1:0] lvl_mode = '1;
  logic [NUM_CH-1:0] raw_in = '0;
  logic [NUM_CH-1:0] filt_out;

  dbx_debounce #(.NUM_CH(NUM_CH), .DBNC_CH(DBNC_CH), .CLK_PER_US(P)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .lvl_mode(lvl_mode),
    .raw_in(raw_in), .filt_out(filt_out)
  );

  always #5 clk = ~clk;

  typedef struct {
    int unsigned at;
    bit          is_rd;
    int          idx;
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int unsigned cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int unsigned delay, input bit is_rd, input int idx,
                      input logic [31:0] exp, input string tag);
    exp_t e;
    int   pos;
    e.at = cyc + delay; e.is_rd = is_rd; e.idx = idx; e.exp = exp; e.tag = tag;
    pos = sb.size();
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].at > e.at) begin pos = i; break; end
    end
    sb.insert(pos, e);
  endtask

  // Monitor: pops expected items as their cycle arrives and compares.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t        e;
      logic [31:0] act;
      e = sb.pop_front();
      act = e.is_rd ? rd_data : {31'b0, filt_out[e.idx]};
      checks++;
      if (act !== e.exp) begin
        errors++;
        $display("FAIL %s: cycle %0d %s[%0d] actual %h expected %h",
                 e.tag, cyc, e.is_rd ? "rd_data" : "filt_out", e.idx, act, e.exp);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_expect(input logic [11:0] a, input logic [31:0] e, input string tag);
    rd_addr = a;
    push(1, 1'b1, 0, e, tag);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_filt(input int ch, input int unsigned delay, input bit v,
                             input string tag);
    push(delay, 1'b0, ch, {31'b0, v}, tag);
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
  endtask

  // Clean step on a filtered channel of lim microseconds.
  task automatic step_check(input int ch, input int lim, input bit v, input string tag);
    raw_in[ch] = v;
    expect_filt(ch, (lim - 1) * P - 2, !v, tag);
    expect_filt(ch, lim * P + 2, v, tag);
    drain();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    push(0, 1'b1, 0, 32'h0, "R8 rd_data");
    for (int c = 0; c < NUM_CH; c++) expect_filt(c, 0, 1'b0, "R8 filt");
    drain();

    // R1 / R3: set en+restart+code2 on ch1, restart bit reads 0
    wr(12'h600, 32'h0000_2300);
    rd_expect(12'h500, 32'h0000_2100, "R1 R3 layout");
    wr(12'h600, 32'h0000_8C00);
    rd_expect(12'h500, 32'h0000_2100, "R1 reserved bits");
    rd_expect(12'h580, 32'h0, "R1 unmatched addr");

    // R2: set ORs, clear removes
    wr(12'h600, 32'h0000_1000);
    rd_expect(12'h500, 32'h0000_3100, "R2 set or");
    wr(12'h700, 32'h0000_2200);
    rd_expect(12'h500, 32'h0000_1100, "R2 clear");
    wr(12'h604, 32'h0000_00FF);
    rd_expect(12'h504, 32'h0000_0071, "R2 set all");
    wr(12'h704, 32'h0000_00FF);
    rd_expect(12'h504, 32'h0000_0000, "R2 wipe");

    // R7: channel 6 is beyond the debounce count
    wr(12'h604, 32'h00FF_0000);
    rd_expect(12'h504, 32'h0000_0000, "R7 field");
    raw_in[6] = 1'b1;
    expect_filt(6, 1, 1'b0, "R7 latency");
    expect_filt(6, 2, 1'b1, "R7 bypass");
    drain();

    // R6: ch0 enabled code0 but edge mode
    wr(12'h600, 32'h0000_0001);
    lvl_mode[0] = 1'b0;
    @(negedge clk);
    raw_in[0] = 1'b1;
    expect_filt(0, 1, 1'b0, "R6 latency");
    expect_filt(0, 2, 1'b1, "R6 edge bypass");
    drain();
    raw_in[0] = 1'b0;
    expect_filt(0, 2, 1'b0, "R6 edge bypass");
    drain();
    // R6: enable off, level mode on (ch3)
    raw_in[3] = 1'b1;
    expect_filt(3, 2, 1'b1, "R6 disabled bypass");
    drain();

    // R5 / R4: clean step, code 0 = 500 us
    lvl_mode[0] = 1'b1;
    @(negedge clk);
    step_check(0, 500, 1'b1, "R5 R4 code0 step");

    // R5: glitch restarts the count
    raw_in[0] = 1'b0;
    repeat (600) @(negedge clk);
    raw_in[0] = 1'b1;
    repeat (20) @(negedge clk);
    step_check(0, 500, 1'b0, "R5 glitch restart");

    // R4: code 1 = 1000 us on ch1
    step_check(1, 1000, 1'b1, "R4 code1");

    // R3: restart write mid-interval delays the switch
    raw_in[0] = 1'b1;
    repeat (600) @(negedge clk);
    wr(12'h600, 32'h0000_0003);
    expect_filt(0, 996 - 1, 1'b0, "R3 restart");
    expect_filt(0, 1006 - 1, 1'b1, "R3 restart");
    drain();
    rd_expect(12'h500, 32'h0000_1101, "R3 reads zero");

    // R4: code 2 = 16000 us on ch2, then code 7 longer than code 2
    wr(12'h600, 32'h0021_0000);
    step_check(2, 16000, 1'b1, "R4 code2");
    wr(12'h600, 32'h0071_0000);
    raw_in[2] = 1'b0;
    expect_filt(2, 40000, 1'b1, "R4 code7 longest");
    drain();

    done = 1'b1;
    summary();
  end
endmodule